// File: doc/BRIEF.md
# Layered Fan and Power-Cap Controller

This block turns periodic temperature samples from a multi-zone server into a fan duty, a GPU power-limit level and a throttle reason. Five temperatures arrive together as registered words, marked by a one-cycle sample strobe: inlet, exhaust, GPU hotspot, VR hotspot and switch/retimer. All state moves only on a strobed sample, so the strobe rate sets the control period.

There are three layers, and each has its own guard against oscillation. The baseline duty follows the exhaust-over-inlet rise. It uses a hysteresis band on its target and a per-sample slope limit. A hotspot layer watches the three component temperatures against an absolute limit and a rise-per-sample limit. A zone must trip on consecutive samples before it asserts, and it then dwells before it can release. While any zone is asserted, a fixed bias is added to the fan. The cap layer is the backstop. It deepens the power limit one level at a time while any zone is at its wall or the fan is saturated. It relaxes one level at a time once neither holds, and it keeps a minimum number of samples between changes.

Top module: `thermal_layer_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, fan_duty is 50, cap_level is 0, thr_code is 0 and fan_sat is 0.
- R2: The baseline target is min(20 + 4*d, 100), where d is exhaust minus inlet, or 0 when exhaust is not above inlet. Temperature changes without smp_valid leave every output unchanged.
- R3: The target held by the baseline is replaced by a newly computed target only when the two differ by more than 4.
- R4: On each sample the baseline duty moves toward the held target by at most 5. The held target is the one after the R3 update of that sample.
- R5: A zone trips on a sample when its temperature is at least 85, or when it rose by at least 5 since the previous sample. The first sample after reset never counts as a rise.
- R6: A zone asserts only on its third consecutive tripping sample. A non-tripping sample clears the count.
- R7: An asserted zone stays asserted through 4 consecutive non-tripping samples and releases on the fifth. Any tripping sample restarts this count.
- R8: fan_duty is baseline plus 30 while any zone is asserted, saturated at 100. fan_sat is 1 exactly when fan_duty is 100.
- R9: On a sample where any zone temperature is at least 95, or fan_sat was 1 before the sample, the cap deepens by one level. The deepest level is 7.
- R10: When neither condition holds, the cap relaxes by one level, down to 0. After any change, the next 3 samples make no change.
- R11: thr_code bit 0 is 1 while any zone is asserted, and bit 1 equals fan_sat. So 0 is none, 1 is hotspot, 2 is fan saturation and 3 is both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | One-cycle strobe: the temperature words form a sample |
| t_inlet | input | TW | Inlet air temperature |
| t_exhaust | input | TW | Exhaust air temperature |
| t_gpu | input | TW | GPU hotspot temperature |
| t_vr | input | TW | VR hotspot temperature |
| t_switch | input | TW | Switch/retimer temperature |
| fan_duty | output | DW | Fan duty in percent, 0 to 100 |
| fan_sat | output | 1 | Fan duty at its maximum |
| cap_level | output | LW | Power-limit index, 0 = no cap, 7 = deepest |
| thr_code | output | 2 | Throttle reason code |

## Verification
Some properties hold on every cycle, and the assertions check those. The baseline never jumps by more than the slope limit and never moves without a strobe. A zone only rises after a tripping sample and only falls after a quiet sample with an exhausted dwell. The cap moves by at most one level, only on a sample and only with its hold spent. The fan output never drops below the baseline or exceeds the maximum. Other behaviour depends on the exact arithmetic and on history, and only the bench's scenarios with a behavioural model can show it. This covers the target formula, where the hysteresis band falls, the exact debounce and dwell counts, the feedback from fan saturation into the cap, and the full climb to level 7 and relaxation back to 0.

// File: rtl/thermctl_pkg.sv
package thermctl_pkg;

    typedef enum logic [1:0] {
        THR_NONE = 2'b00,
        THR_HOT  = 2'b01,
        THR_FAN  = 2'b10,
        THR_BOTH = 2'b11
    } thr_code_e;

    typedef enum logic {
        ZONE_QUIET = 1'b0,
        ZONE_HELD  = 1'b1
    } zone_state_e;

    function automatic int clamp_hi(int v, int lim);
        return (v > lim) ? lim : v;
    endfunction

    function automatic int abs_diff(int a, int b);
        return (a > b) ? a - b : b - a;
    endfunction

    function automatic int step_toward(int cur, int tgt, int slew);
        if (cur < tgt) return cur + clamp_hi(tgt - cur, slew);
        if (cur > tgt) return cur - clamp_hi(cur - tgt, slew);
        return cur;
    endfunction

endpackage

// File: rtl/fan_curve.sv
module fan_curve
    import thermctl_pkg::*;
#(
    parameter int TW       = 8,
    parameter int DW       = 7,
    parameter int BASE_MIN = 20,
    parameter int GAIN     = 4,
    parameter int HYST     = 4,
    parameter int SLEW     = 5,
    parameter int SAFE     = 50,
    parameter int DMAX     = 100
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          valid,
    input  logic [TW-1:0] t_in,
    input  logic [TW-1:0] t_ex,
    output logic [DW-1:0] base
);
    logic [DW-1:0] tgt_q, tgt_new, tgt_next, base_next;
    int rise_i, raw_i;

    always_comb begin
        rise_i   = (t_ex > t_in) ? (int'(t_ex) - int'(t_in)) : 0;
        raw_i    = BASE_MIN + GAIN * rise_i;
        tgt_new  = DW'(clamp_hi(raw_i, DMAX));
        tgt_next = (abs_diff(int'(tgt_new), int'(tgt_q)) > HYST) ? tgt_new : tgt_q;
        base_next = DW'(step_toward(int'(base), int'(tgt_next), SLEW));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_q <= DW'(SAFE);
            base  <= DW'(SAFE);
        end else if (valid) begin
            tgt_q <= tgt_next;
            base  <= base_next;
        end
    end

    // R4: baseline never moves more than the slope limit per cycle
    assert_slew_limit_R4: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> ((base >= $past(base)) ? (base - $past(base)) : ($past(base) - base)) <= DW'(SLEW));

    // R2: without a strobe the baseline holds
    assert_hold_no_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !$past(valid)) |-> $stable(base));

endmodule

// File: rtl/hotspot_zone.sv
module hotspot_zone
    import thermctl_pkg::*;
#(
    parameter int TW      = 8,
    parameter int HOT_TH  = 85,
    parameter int RATE_TH = 5,
    parameter int DEB     = 3,
    parameter int DWELL   = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          valid,
    input  logic [TW-1:0] temp,
    output logic          hot
);
    localparam int CW = $clog2(DEB + 1);
    localparam int WW = $clog2(DWELL + 1);
    localparam logic [TW-1:0] HOT_T  = TW'(HOT_TH);
    localparam logic [TW-1:0] RATE_T = TW'(RATE_TH);

    zone_state_e   st;
    logic [TW-1:0] prev_q;
    logic          prev_ok;
    logic [CW-1:0] cnt;
    logic [WW-1:0] dw;
    logic          trip;

    always_comb begin
        trip = (temp >= HOT_T) ||
               (prev_ok && (temp > prev_q) && ((temp - prev_q) >= RATE_T));
    end

    assign hot = (st == ZONE_HELD);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ZONE_QUIET;
            prev_q  <= '0;
            prev_ok <= 1'b0;
            cnt     <= '0;
            dw      <= '0;
        end else if (valid) begin
            prev_q  <= temp;
            prev_ok <= 1'b1;
            case (st)
                ZONE_QUIET: begin
                    if (!trip) begin
                        cnt <= '0;
                    end else if (cnt == CW'(DEB - 1)) begin
                        st  <= ZONE_HELD;
                        dw  <= WW'(DWELL);
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (trip)         dw <= WW'(DWELL);
                    else if (dw != 0) dw <= dw - 1'b1;
                    else              st <= ZONE_QUIET;
                end
            endcase
        end
    end

    // R6: assertion only follows a tripping strobed sample
    assert_rise_needs_trip_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(hot) |-> ($past(valid) && $past(trip)));

    // R7: release only after the dwell is spent on a quiet sample
    assert_release_after_dwell_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(hot) |-> ($past(valid) && !$past(trip) && ($past(dw) == 0)));

endmodule

// File: rtl/cap_stepper.sv
module cap_stepper
    import thermctl_pkg::*;
#(
    parameter int LW   = 3,
    parameter int HOLD = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          valid,
    input  logic          engage,
    output logic [LW-1:0] level
);
    localparam int HW = $clog2(HOLD + 1);
    localparam logic [LW-1:0] LMAX = {LW{1'b1}};

    logic [HW-1:0] hcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= '0;
            hcnt  <= '0;
        end else if (valid) begin
            if (hcnt != 0) begin
                hcnt <= hcnt - 1'b1;
            end else if (engage && level != LMAX) begin
                level <= level + 1'b1;
                hcnt  <= HW'(HOLD - 1);
            end else if (!engage && level != '0) begin
                level <= level - 1'b1;
                hcnt  <= HW'(HOLD - 1);
            end
        end
    end

    // R10: any change happens on a sample with the hold spent, by one step
    assert_hold_respected_R10: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && (level != $past(level))) |->
            ($past(valid) && ($past(hcnt) == 0) &&
             ((level == $past(level) + 1'b1) || (level == $past(level) - 1'b1))));

    // R9: engaged sample with free hold deepens the cap
    assert_engage_steps_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(valid && engage && (hcnt == 0) && (level != LMAX))) |->
            (level == $past(level) + 1'b1));

endmodule

// File: rtl/thermal_layer_ctrl.sv
module thermal_layer_ctrl
    import thermctl_pkg::*;
#(
    parameter int TW       = 8,
    parameter int DW       = 7,
    parameter int LW       = 3,
    parameter int DMAX     = 100,
    parameter int SAFE     = 50,
    parameter int BASE_MIN = 20,
    parameter int GAIN     = 4,
    parameter int HYST     = 4,
    parameter int SLEW     = 5,
    parameter int HOT_TH   = 85,
    parameter int RATE_TH  = 5,
    parameter int WALL_TH  = 95,
    parameter int DEB      = 3,
    parameter int DWELL    = 4,
    parameter int HOLD     = 4,
    parameter int HOT_BIAS = 30
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          smp_valid,
    input  logic [TW-1:0] t_inlet,
    input  logic [TW-1:0] t_exhaust,
    input  logic [TW-1:0] t_gpu,
    input  logic [TW-1:0] t_vr,
    input  logic [TW-1:0] t_switch,
    output logic [DW-1:0] fan_duty,
    output logic          fan_sat,
    output logic [LW-1:0] cap_level,
    output logic [1:0]    thr_code
);
    localparam int NZ = 3;
    localparam logic [TW-1:0] WALL_T = TW'(WALL_TH);

    logic [TW-1:0] zt [NZ];
    logic [NZ-1:0] zone_hot, zone_wall;
    logic [DW-1:0] base_duty;
    logic          any_hot, engage;
    thr_code_e     thr_e;

    assign zt[0] = t_gpu;
    assign zt[1] = t_vr;
    assign zt[2] = t_switch;

    fan_curve #(
        .TW(TW), .DW(DW), .BASE_MIN(BASE_MIN), .GAIN(GAIN), .HYST(HYST),
        .SLEW(SLEW), .SAFE(SAFE), .DMAX(DMAX)
    ) u_curve (
        .clk(clk), .rst(rst), .valid(smp_valid),
        .t_in(t_inlet), .t_ex(t_exhaust), .base(base_duty)
    );

    for (genvar g = 0; g < NZ; g++) begin : g_zone
        hotspot_zone #(
            .TW(TW), .HOT_TH(HOT_TH), .RATE_TH(RATE_TH), .DEB(DEB), .DWELL(DWELL)
        ) u_zone (
            .clk(clk), .rst(rst), .valid(smp_valid),
            .temp(zt[g]), .hot(zone_hot[g])
        );
        assign zone_wall[g] = (zt[g] >= WALL_T);
    end

    assign any_hot  = |zone_hot;
    assign fan_duty = DW'(clamp_hi(int'(base_duty) + (any_hot ? HOT_BIAS : 0), DMAX));
    assign fan_sat  = (fan_duty == DW'(DMAX));
    assign engage   = (|zone_wall) | fan_sat;
    assign thr_e    = thr_code_e'({fan_sat, any_hot});
    assign thr_code = thr_e;

    cap_stepper #(.LW(LW), .HOLD(HOLD)) u_cap (
        .clk(clk), .rst(rst), .valid(smp_valid),
        .engage(engage), .level(cap_level)
    );

    // R8: combined duty stays between the baseline and the maximum
    assert_duty_bounded_R8: assert property (@(posedge clk) disable iff (rst)
        (fan_duty >= base_duty) && (fan_duty <= DW'(DMAX)));

    // R1: state left by reset
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ((cap_level == '0) && (base_duty == DW'(SAFE)) && !any_hot));

endmodule

// File: tb/sim_thermal_layer_ctrl.sv
module sim_thermal_layer_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       smp_valid = 1'b0;
    logic [7:0] t_inlet = 8'd25, t_exhaust = 8'd30, t_gpu = 8'd60, t_vr = 8'd60, t_switch = 8'd60;
    logic [6:0] fan_duty;
    logic       fan_sat;
    logic [2:0] cap_level;
    logic [1:0] thr_code;

    int total = 0, bad = 0, cycles = 0;
    bit done = 0;
    string phase = "R1 reset";

    // behavioural model state
    int m_base, m_tgt, m_cap, m_hold;
    int m_prev[3], m_cnt[3], m_dw[3];
    bit m_hot[3];
    bit m_pv;

    always #(CLK_PERIOD/2) clk = ~clk;

    thermal_layer_ctrl u0 (
        .clk(clk), .rst(rst), .smp_valid(smp_valid),
        .t_inlet(t_inlet), .t_exhaust(t_exhaust), .t_gpu(t_gpu), .t_vr(t_vr), .t_switch(t_switch),
        .fan_duty(fan_duty), .fan_sat(fan_sat), .cap_level(cap_level), .thr_code(thr_code)
    );

    function automatic bit any_hot_m();
        return m_hot[0] | m_hot[1] | m_hot[2];
    endfunction

    function automatic int duty_m();
        int s = m_base + (any_hot_m() ? 30 : 0);
        return (s > 100) ? 100 : s;
    endfunction

    task automatic chk(string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL [%s] %s act=%0d exp=%0d", phase, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_base = 50; m_tgt = 50; m_cap = 0; m_hold = 0; m_pv = 0;
            for (int z = 0; z < 3; z++) begin
                m_prev[z] = 0; m_cnt[z] = 0; m_dw[z] = 0; m_hot[z] = 0;
            end
        end else if (smp_valid) begin
            int zt[3];
            bit eng, trip;
            int d, t;
            zt[0] = t_gpu; zt[1] = t_vr; zt[2] = t_switch;
            // R9/R10 cap uses fan saturation from before this sample
            eng = (duty_m() == 100) || (zt[0] >= 95) || (zt[1] >= 95) || (zt[2] >= 95);
            if (m_hold != 0) m_hold--;
            else if (eng && m_cap < 7) begin m_cap++; m_hold = 3; end
            else if (!eng && m_cap > 0) begin m_cap--; m_hold = 3; end
            // R2/R3/R4 baseline
            d = (int'(t_exhaust) > int'(t_inlet)) ? int'(t_exhaust) - int'(t_inlet) : 0;
            t = 20 + 4 * d;
            if (t > 100) t = 100;
            if ((t > m_tgt ? t - m_tgt : m_tgt - t) > 4) m_tgt = t;
            if (m_base < m_tgt) m_base += (m_tgt - m_base > 5) ? 5 : m_tgt - m_base;
            else if (m_base > m_tgt) m_base -= (m_base - m_tgt > 5) ? 5 : m_base - m_tgt;
            // R5/R6/R7 zones
            for (int z = 0; z < 3; z++) begin
                trip = (zt[z] >= 85) || (m_pv && zt[z] > m_prev[z] && zt[z] - m_prev[z] >= 5);
                if (!m_hot[z]) begin
                    if (!trip) m_cnt[z] = 0;
                    else if (m_cnt[z] == 2) begin m_hot[z] = 1; m_dw[z] = 4; m_cnt[z] = 0; end
                    else m_cnt[z]++;
                end else begin
                    if (trip) m_dw[z] = 4;
                    else if (m_dw[z] != 0) m_dw[z]--;
                    else m_hot[z] = 0;
                end
                m_prev[z] = zt[z];
            end
            m_pv = 1;
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R8 fan_duty", int'(fan_duty), duty_m());
            chk("R8 fan_sat", int'(fan_sat), int'(duty_m() == 100));
            chk("R9 R10 cap_level", int'(cap_level), m_cap);
            chk("R11 thr_code", int'(thr_code), (duty_m() == 100 ? 2 : 0) + (any_hot_m() ? 1 : 0));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            total++; bad++;
            $display("FAIL [watchdog] run hung act=%0d exp=%0d", cycles, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic smp(int ti, int te, int g, int v, int s);
        @(negedge clk);
        t_inlet = 8'(ti); t_exhaust = 8'(te); t_gpu = 8'(g); t_vr = 8'(v); t_switch = 8'(s);
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        phase = "R1 reset";
        chk("R1 duty", int'(fan_duty), 50);
        chk("R1 cap", int'(cap_level), 0);
        chk("R1 code", int'(thr_code), 0);
        chk("R1 sat", int'(fan_sat), 0);

        phase = "R2 target";
        repeat (4) smp(30, 40, 60, 60, 60);
        chk("R2 duty settles at 60", int'(fan_duty), 60);
        phase = "R2 ignored without strobe";
        @(negedge clk); t_exhaust = 8'd90; t_gpu = 8'd99; t_switch = 8'd99;
        repeat (6) @(negedge clk);
        chk("R2 duty unchanged", int'(fan_duty), 60);
        chk("R2 cap unchanged", int'(cap_level), 0);

        phase = "R3 hysteresis";
        repeat (3) smp(30, 41, 60, 60, 60);
        chk("R3 duty held inside band", int'(fan_duty), 60);
        repeat (3) smp(30, 42, 60, 60, 60);
        chk("R3 duty follows past band", int'(fan_duty), 68);
        repeat (3) smp(30, 26, 60, 60, 60);

        phase = "R4 slope";
        smp(30, 50, 60, 60, 60);
        repeat (20) smp(30, 50, 60, 60, 60);
        phase = "R4 slope down";
        repeat (30) smp(30, 32, 60, 60, 60);

        phase = "R5 R6 debounce short";
        repeat (2) smp(30, 32, 88, 60, 60);
        repeat (2) smp(30, 32, 60, 60, 60);
        chk("R6 no assert after two trips", int'(thr_code[0]), 0);
        phase = "R6 debounce full";
        repeat (3) smp(30, 32, 88, 60, 60);
        chk("R6 asserted after three", int'(thr_code[0]), 1);
        phase = "R7 dwell";
        repeat (4) smp(30, 32, 60, 60, 60);
        chk("R7 still held in dwell", int'(thr_code[0]), 1);
        smp(30, 32, 60, 60, 60);
        chk("R7 released", int'(thr_code[0]), 0);

        phase = "R5 rate rise";
        smp(30, 32, 60, 40, 60);
        for (int k = 1; k <= 5; k++) smp(30, 32, 60, 40 + 6 * k, 60);
        repeat (8) smp(30, 32, 60, 70, 60);

        phase = "R9 wall";
        repeat (40) smp(30, 32, 60, 60, 96);
        chk("R9 cap at deepest", int'(cap_level), 7);
        phase = "R10 release";
        repeat (80) smp(30, 32, 60, 60, 60);
        chk("R10 cap back to zero", int'(cap_level), 0);

        phase = "R9 fan saturation path";
        repeat (20) smp(30, 60, 60, 60, 60);
        repeat (20) smp(30, 32, 60, 60, 60);

        phase = "R11 mixed random";
        for (int k = 0; k < 400; k++) begin
            int ti = int'($urandom_range(40, 20));
            smp(ti, ti + int'($urandom_range(25, 0)) - 3,
                int'($urandom_range(99, 55)), int'($urandom_range(99, 55)), int'($urandom_range(99, 55)));
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule